// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits next to an asynchronous static RAM port and watches the accesses made to it. It looks for commands hidden in ordinary read traffic. A command is an exact, ordered series of six reads. The first five addresses are a fixed preamble. The sixth address picks the command: either save the array contents to shadow storage, or restore them from it. Any other access in the middle of the series cancels it.

The chip-enable, write-enable and address lines, plus a supply-low inhibit, are sampled by a system clock through a two-flop synchronizer. A step is recognised on each completed low pulse of chip enable. The address used for that step is the one captured while enable was low.

When a complete series is seen, the block raises a one-cycle request pulse. The host logic uses this pulse to start the nonvolatile transfer. The block does not perform the transfer itself. The output-enable level takes no part in recognition, so it is not an input.

Top module: `cmd_seq_detect`

## Requirements
- R1: After the preamble 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, a sixth read at 0x0FC0 gives exactly one `store_req` pulse, one clock wide. The pulse is high in the fourth clock cycle after the rising clock edge that first samples `ce_n` high.
- R2: The preamble followed by a sixth read at 0x0C63 gives exactly one one-cycle `recall_req` pulse, and no `store_req`.
- R3: Only address bits 13..0 are compared. Bit 14 may take either value on any step without changing the result.
- R4: A step is one low pulse of `ce_n`, counted once however many clocks the pulse lasts. The step uses the address present while `ce_n` is low.
- R5: A `ce_n` low pulse during which `we_n` is low at any sampled cycle is a write. A write cancels a series in progress and never counts as a step.
- R6: A read whose address is not the next one expected cancels the series. No request is issued for the remaining reads of that series.
- R7: A sixth read at 0x339C after a full preamble issues neither request.
- R8: While `store_inhibit` is high, a completed store series issues no `store_req`. A recall series still issues `recall_req`.
- R9: A read at 0x0E38 that cancels a series is counted as step 1 of a new series.
- R10: While `rst_n` is low, both requests are low. A reset clears any partly seen series, so a later sixth read issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Memory chip enable, active low, asynchronous |
| we_n | input | 1 | Memory write enable, active low, asynchronous |
| addr | input | ADDR_W | Memory address bus, asynchronous |
| store_inhibit | input | 1 | Supply-low indication; blocks store requests |
| store_req | output | 1 | One-cycle request to save the array to shadow storage |
| recall_req | output | 1 | One-cycle request to restore the array from shadow storage |

## Verification
The embedded properties assume the following about the inputs:
- Every low and high phase of `ce_n` lasts at least two clocks, so that each edge reaches the synchronized domain.
- The address and `we_n` stay steady for the whole low phase.

Under these conditions, two capture pulses can never fall in adjacent cycles, and a request can only come from the state holding the full preamble. The directed stimulus follows these rules throughout:
- Each access holds `ce_n` low for at least three clocks and then high for three.
- The address and write level are changed only while `ce_n` is high.
- For the mid-pulse write case, `we_n` falls while `ce_n` is still low and returns high only after `ce_n` has risen.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  localparam int unsigned KEY_W = 14;

  localparam logic [KEY_W-1:0] KEY_P0     = 14'h0E38;
  localparam logic [KEY_W-1:0] KEY_P1     = 14'h31C7;
  localparam logic [KEY_W-1:0] KEY_P2     = 14'h03E0;
  localparam logic [KEY_W-1:0] KEY_P3     = 14'h3C1F;
  localparam logic [KEY_W-1:0] KEY_P4     = 14'h303F;
  localparam logic [KEY_W-1:0] KEY_SAVE   = 14'h0FC0;
  localparam logic [KEY_W-1:0] KEY_LOAD   = 14'h0C63;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4,
    ST_S5   = 3'd5
  } seq_st_e;

  // address expected as the next step while in a given state
  function automatic logic [KEY_W-1:0] expect_key(seq_st_e st);
    case (st)
      ST_IDLE: expect_key = KEY_P0;
      ST_S1:   expect_key = KEY_P1;
      ST_S2:   expect_key = KEY_P2;
      ST_S3:   expect_key = KEY_P3;
      default: expect_key = KEY_P4;
    endcase
  endfunction

  function automatic seq_st_e advance(seq_st_e st);
    case (st)
      ST_IDLE: advance = ST_S1;
      ST_S1:   advance = ST_S2;
      ST_S2:   advance = ST_S3;
      ST_S3:   advance = ST_S4;
      default: advance = ST_S5;
    endcase
  endfunction

endpackage

// File: rtl/rsd_sync.sv
module rsd_sync #(
  parameter int unsigned       WIDTH   = 4,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/rsd_capture.sv
module rsd_capture #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_s,
  input  logic              we_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              step_vld_o,
  output logic              step_rd_o,
  output logic [ADDR_W-1:0] step_addr_o
);

  logic              ce_prev_q;
  logic [ADDR_W-1:0] hold_q, hold_d;
  logic              wr_seen_q, wr_seen_d;
  logic              vld_q, vld_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] saddr_q, saddr_d;
  logic              ce_fall, ce_rise, ce_low;

  assign ce_low  = ~ce_n_s;
  assign ce_fall = ce_low & ce_prev_q;
  assign ce_rise = ~ce_low & ~ce_prev_q;

  always_comb begin
    hold_d    = hold_q;
    wr_seen_d = wr_seen_q;
    saddr_d   = saddr_q;
    rd_d      = rd_q;
    vld_d     = ce_rise;
    if (ce_low) begin
      hold_d = addr_s;
      if (ce_fall) wr_seen_d = ~we_n_s;
      else         wr_seen_d = wr_seen_q | ~we_n_s;
    end
    if (ce_rise) begin
      saddr_d = hold_q;
      rd_d    = ~wr_seen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev_q <= 1'b1;
      hold_q    <= '0;
      wr_seen_q <= 1'b0;
      vld_q     <= 1'b0;
      rd_q      <= 1'b0;
      saddr_q   <= '0;
    end else begin
      ce_prev_q <= ~ce_low;
      hold_q    <= hold_d;
      wr_seen_q <= wr_seen_d;
      vld_q     <= vld_d;
      rd_q      <= rd_d;
      saddr_q   <= saddr_d;
    end
  end

  assign step_vld_o  = vld_q;
  assign step_rd_o   = rd_q;
  assign step_addr_o = saddr_q;

  // R4
  step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld_o |=> !step_vld_o);

endmodule

// File: rtl/rsd_seq.sv
module rsd_seq
  import rsd_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_vld_i,
  input  logic              step_rd_i,
  input  logic [ADDR_W-1:0] step_addr_i,
  input  logic              inhibit_i,
  output logic              store_o,
  output logic              recall_o
);

  localparam logic [ADDR_W-1:0] CMP_MASK = ADDR_W'((1 << KEY_W) - 1);

  seq_st_e st_q, st_d;
  logic    store_q, store_d;
  logic    recall_q, recall_d;
  logic    hit_exp, hit_start, hit_save, hit_load;

  function automatic logic key_eq(logic [ADDR_W-1:0] a, logic [KEY_W-1:0] k);
    key_eq = ((a & CMP_MASK) == ADDR_W'(k));
  endfunction

  assign hit_exp   = key_eq(step_addr_i, expect_key(st_q));
  assign hit_start = key_eq(step_addr_i, KEY_P0);
  assign hit_save  = key_eq(step_addr_i, KEY_SAVE);
  assign hit_load  = key_eq(step_addr_i, KEY_LOAD);

  always_comb begin
    st_d     = st_q;
    store_d  = 1'b0;
    recall_d = 1'b0;
    if (step_vld_i) begin
      if (!step_rd_i) begin
        st_d = ST_IDLE;
      end else if (st_q == ST_S5) begin
        if (hit_save) begin
          store_d = ~inhibit_i;
          st_d    = ST_IDLE;
        end else if (hit_load) begin
          recall_d = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          st_d = hit_start ? ST_S1 : ST_IDLE;
        end
      end else if (hit_exp) begin
        st_d = advance(st_q);
      end else begin
        st_d = hit_start ? ST_S1 : ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      store_q  <= store_d;
      recall_q <= recall_d;
    end
  end

  assign store_o  = store_q;
  assign recall_o = recall_q;

  // R1
  store_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_q |=> !store_q);
  // R2
  recall_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_q |=> !recall_q);
  // R2
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_q && recall_q));
  // R6
  req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_q || recall_q) |-> ($past(st_q) == ST_S5 && st_q == ST_IDLE));
  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_q |-> !$past(inhibit_i));

endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              store_inhibit,
  output logic              store_req,
  output logic              recall_req
);

  localparam int unsigned BUS_W = ADDR_W + 3;
  localparam logic [BUS_W-1:0] BUS_RST = {1'b0, 1'b1, 1'b1, {ADDR_W{1'b0}}};

  logic              rst_m_q, rst_s_q;
  logic [BUS_W-1:0]  bus_s;
  logic              inh_s, we_s, ce_s;
  logic [ADDR_W-1:0] addr_s;
  logic              step_vld, step_rd;
  logic [ADDR_W-1:0] step_addr;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  rsd_sync #(.WIDTH(BUS_W), .RST_VAL(BUS_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_q),
    .d_i   ({store_inhibit, we_n, ce_n, addr}),
    .q_o   (bus_s)
  );

  assign {inh_s, we_s, ce_s, addr_s} = bus_s;

  rsd_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .ce_n_s      (ce_s),
    .we_n_s      (we_s),
    .addr_s      (addr_s),
    .step_vld_o  (step_vld),
    .step_rd_o   (step_rd),
    .step_addr_o (step_addr)
  );

  rsd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .step_vld_i  (step_vld),
    .step_rd_i   (step_rd),
    .step_addr_i (step_addr),
    .inhibit_i   (inh_s),
    .store_o     (store_req),
    .recall_o    (recall_req)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_s_q |-> (!store_req && !recall_req));

endmodule

// File: tb/sim_cmd_seq_detect.sv
`timescale 1ns/1ps
module sim_cmd_seq_detect;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n, inh;
  logic [14:0] addr;
  logic        store_req, recall_req;

  int n_chk = 0;
  int n_bad = 0;
  int n_store = 0;
  int n_recall = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_seq_detect #(.ADDR_W(15)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .store_inhibit(inh), .store_req(store_req), .recall_req(recall_req)
  );

  always @(negedge clk) begin
    if (store_req)  n_store++;
    if (recall_req) n_recall++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(logic [14:0] a, int low = 3);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0;
    repeat (low) @(negedge clk);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [14:0] a);
    @(negedge clk);
    addr = a; we_n = 1'b0; ce_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic preamble(logic [14:0] hi = 15'h0);
    rd(15'h0E38 | hi); rd(15'h31C7 | hi); rd(15'h03E0 | hi);
    rd(15'h3C1F | hi); rd(15'h303F | hi);
  endtask

  task automatic settle_clear();
    repeat (8) @(negedge clk);
    n_store = 0; n_recall = 0;
  endtask

  task automatic expect_counts(string req, int s, int r);
    repeat (8) @(negedge clk);
    chk({req, " store count"}, n_store, s);
    chk({req, " recall count"}, n_recall, r);
    n_store = 0; n_recall = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; inh = 1'b0; addr = '0;
    repeat (4) @(negedge clk);
    chk("R10 store low in reset", int'(store_req), 0);
    chk("R10 recall low in reset", int'(recall_req), 0);
    rst_n = 1'b1;
    settle_clear();
  endtask

  task automatic t_store_latency();
    int at = 0;
    preamble();
    @(negedge clk);
    addr = 15'h0FC0; we_n = 1'b1; ce_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (store_req && at == 0) at = k;
    end
    chk("R1 store pulse cycle", at, 4);
    expect_counts("R1", 1, 0);
  endtask

  task automatic t_recall();
    preamble(); rd(15'h0C63);
    expect_counts("R2", 0, 1);
  endtask

  task automatic t_bit14();
    preamble(15'h4000); rd(15'h4FC0);
    expect_counts("R3 bit14 set", 1, 0);
    rd(15'h0E38); rd(15'h71C7); rd(15'h03E0); rd(15'h7C1F); rd(15'h303F);
    rd(15'h4C63);
    expect_counts("R3 bit14 mixed", 0, 1);
  endtask

  task automatic t_long_pulse();
    rd(15'h0E38, 7); rd(15'h31C7, 5); rd(15'h03E0, 9);
    rd(15'h3C1F, 6); rd(15'h303F, 4); rd(15'h0FC0, 8);
    expect_counts("R4 long pulses", 1, 0);
  endtask

  task automatic t_write_abort();
    rd(15'h0E38); rd(15'h31C7); wr(15'h03E0);
    rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);
    expect_counts("R5 write between steps", 0, 0);
    // write enable dropping inside a read pulse voids the step
    rd(15'h0E38); rd(15'h31C7);
    @(negedge clk);
    addr = 15'h03E0; we_n = 1'b1; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (2) @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);
    expect_counts("R5 write inside pulse", 0, 0);
    wr(15'h0E38); rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F);
    rd(15'h303F); rd(15'h0FC0);
    expect_counts("R5 write not step one", 0, 0);
  endtask

  task automatic t_wrong();
    rd(15'h0E38); rd(15'h31C7); rd(15'h1234);
    rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);
    expect_counts("R6 stray read", 0, 0);
    rd(15'h0E38); rd(15'h03E0); rd(15'h31C7);
    rd(15'h3C1F); rd(15'h303F); rd(15'h0C63);
    expect_counts("R6 swapped order", 0, 0);
  endtask

  task automatic t_reserved();
    preamble(); rd(15'h339C);
    expect_counts("R7 reserved sixth", 0, 0);
    rd(15'h0FC0);
    expect_counts("R7 state idle after", 0, 0);
  endtask

  task automatic t_inhibit();
    @(negedge clk); inh = 1'b1;
    repeat (4) @(negedge clk);
    preamble(); rd(15'h0FC0);
    expect_counts("R8 store inhibited", 0, 0);
    preamble(); rd(15'h0C63);
    expect_counts("R8 recall allowed", 0, 1);
    inh = 1'b0;
    repeat (4) @(negedge clk);
    preamble(); rd(15'h0FC0);
    expect_counts("R8 store after release", 1, 0);
  endtask

  task automatic t_restart();
    rd(15'h0E38); rd(15'h31C7); rd(15'h0E38);
    rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);
    expect_counts("R9 restart on start key", 1, 0);
    preamble(); rd(15'h0E38);
    rd(15'h31C7); rd(15'h03E0); rd(15'h3C1F); rd(15'h303F); rd(15'h0C63);
    expect_counts("R9 restart at sixth", 0, 1);
  endtask

  task automatic t_reset_mid();
    preamble();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(15'h0FC0);
    expect_counts("R10 reset clears series", 0, 0);
  endtask

  initial begin
    t_reset();
    t_store_latency();
    t_recall();
    t_bit14();
    t_long_pulse();
    t_write_abort();
    t_wrong();
    t_reserved();
    t_inhibit();
    t_restart();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule